// File: doc/BRIEF.md
# Serial Port Interrupt and DMA Request Controller

This block turns the status events of a FIFO-buffered serial port into interrupt and DMA request lines. The transmit and receive datapaths pulse single-cycle events (transmit FIFO empty, receive FIFO full, receive data ready, receive error, break, overrun). Each event sets a sticky status flag. Four registered interrupt lines and two registered DMA request lines are derived from those flags, the enable bits and the mode bit.

Software reaches the block through a small register port. Address 0 is the control register and address 1 is the status register. A flag is cleared either by a software write of 0 after the flag has been read as 1, or by a DMA acknowledge. For the two level-based flags, a clear is held off while the FIFO condition behind the flag still holds. DMA requests do not depend on the interrupt enables, so a DMA engine can drain the FIFOs with the interrupts masked.

Top module: `sio_req_ctrl`

## Requirements
- R1: A synchronous reset clears every status flag, the control register and all six request outputs.
- R2: Control bit 0 is the transmit interrupt enable. `dreq_tx` is high whenever status bit 0 (transmit empty) is set, whatever the enables hold. `irq_tx` is high only when status bit 0 and control bit 0 are both 1.
- R3: In asynchronous mode (control bit 3 = 0), `dreq_rx` is high when status bit 1 (receive full) or status bit 2 (data ready) is set. `irq_rx` is high under the same condition, and only when control bit 1 (receive interrupt enable) is also 1.
- R4: In synchronous mode (control bit 3 = 1), status bit 2 raises neither `dreq_rx` nor `irq_rx`; only status bit 1 counts. Status bit 2 still reads back as 1.
- R5: `irq_err` is high when status bit 3 (receive error) is set and control bit 1 or control bit 2 (error enable) is 1. With bit 2 set and bit 1 clear, `irq_err` rises while `irq_rx` stays low.
- R6: `irq_brk` is high when status bit 4 (break) or status bit 5 (overrun) is set, with no enable.
- R7: Flags are sticky. Writing 0 to a status bit clears it only if that bit was read as 1 beforehand. A write of 0 without a prior read leaves the bit set. Writing 1 has no effect.
- R8: When a set event and a clear (software or DMA) reach the same flag in the same cycle, the flag stays set.
- R9: A pulse on `dma_tx_ack` clears status bit 0. A pulse on `dma_rx_ack` clears status bits 1 and 2. The request and interrupt outputs then fall.
- R10: A clear of status bit 0 is ignored while `lvl_tx_empty` is high. A clear of status bit 1 is ignored while `lvl_rx_full` is high.
- R11: Every request output is registered. It changes one clock after the flag or control change that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_tx_empty | input | 1 | Transmit FIFO empty event pulse |
| ev_rx_full | input | 1 | Receive FIFO full event pulse |
| ev_rx_ready | input | 1 | Receive data ready event pulse |
| ev_rx_err | input | 1 | Receive error event pulse |
| ev_break | input | 1 | Break detected event pulse |
| ev_overrun | input | 1 | Overrun event pulse |
| lvl_tx_empty | input | 1 | Transmit FIFO currently below threshold |
| lvl_rx_full | input | 1 | Receive FIFO currently at or above threshold |
| dma_tx_ack | input | 1 | DMA acknowledge for transmit request |
| dma_rx_ack | input | 1 | DMA acknowledge for receive request |
| reg_addr | input | 1 | 0 selects control, 1 selects status |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-data interrupt |
| irq_err | output | 1 | Receive-error interrupt |
| irq_brk | output | 1 | Break/overrun interrupt |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |

## Verification
A clear and a new set event can reach the same flag in the same cycle. The clear can be a software write of 0 after a read, or a DMA acknowledge. The bench provokes both cases by driving the event pulse on the same negedge as the write strobe or the acknowledge. The case passes if the status bit still reads 1 afterwards and the matching request output stays high in the following cycle.

// File: rtl/sio_req_ctrl.sv
module sio_req_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_tx_empty,
  input  logic          ev_rx_full,
  input  logic          ev_rx_ready,
  input  logic          ev_rx_err,
  input  logic          ev_break,
  input  logic          ev_overrun,
  input  logic          lvl_tx_empty,
  input  logic          lvl_rx_full,
  input  logic          dma_tx_ack,
  input  logic          dma_rx_ack,
  input  logic          reg_addr,
  input  logic          reg_we,
  input  logic          reg_re,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_tx,
  output logic          irq_rx,
  output logic          irq_err,
  output logic          irq_brk,
  output logic          dreq_tx,
  output logic          dreq_rx
);
  localparam int NF = 6;
  localparam int NC = 4;

  logic [NC-1:0] ctl;
  logic [NF-1:0] st, seen, ev, sw_clr, clr, rd_mask;
  logic          tx_ie, rx_ie, er_ie, sync_md, rx_req;

  assign {sync_md, er_ie, rx_ie, tx_ie} = ctl;
  assign ev = {ev_overrun, ev_break, ev_rx_err, ev_rx_ready, ev_rx_full, ev_tx_empty};

  assign rd_mask = (reg_re && reg_addr) ? st : '0;
  assign sw_clr  = (reg_we && reg_addr) ? (~reg_wdata[NF-1:0] & seen) : '0;
  assign clr[0]  = (sw_clr[0] | dma_tx_ack) & ~lvl_tx_empty;
  assign clr[1]  = (sw_clr[1] | dma_rx_ack) & ~lvl_rx_full;
  assign clr[2]  = sw_clr[2] | dma_rx_ack;
  assign clr[NF-1:3] = sw_clr[NF-1:3];

  assign reg_rdata = reg_addr ? DW'(st) : DW'(ctl);
  assign rx_req = st[1] | (st[2] & ~sync_md);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl  <= '0;
      st   <= '0;
      seen <= '0;
    end else begin
      if (reg_we && !reg_addr) ctl <= reg_wdata[NC-1:0];
      st   <= ev | (st & ~clr);
      seen <= (seen | rd_mask) & ~clr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx} <= '0;
    end else begin
      dreq_tx <= st[0];
      irq_tx  <= st[0] & tx_ie;
      dreq_rx <= rx_req;
      irq_rx  <= rx_req & rx_ie;
      irq_err <= st[3] & (rx_ie | er_ie);
      irq_brk <= st[4] | st[5];
    end
  end

  AST_TXREQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    ev_tx_empty |=> ##1 dreq_tx);                                     // R2
  AST_RXIRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(rx_ie));                                         // R3
  AST_SYNC_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (sync_md && !st[1] && !irq_rx && !dreq_rx && $stable(sync_md)) |=> !irq_rx); // R4
  AST_BRK_ON_EVENT: assert property (@(posedge clk) disable iff (rst)
    (ev_break || ev_overrun) |=> ##1 irq_brk);                        // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ev_rx_err |=> st[3]);                                             // R8
  AST_GUARD_TX: assert property (@(posedge clk) disable iff (rst)
    (st[0] && lvl_tx_empty) |=> st[0]);                               // R10
  AST_GUARD_RX: assert property (@(posedge clk) disable iff (rst)
    (st[1] && lvl_rx_full) |=> st[1]);                                // R10
  AST_NO_ENABLE_IRQ: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> dreq_tx);                                              // R2
endmodule

// File: tb/sio_req_ctrl_test.sv
module sio_req_ctrl_test;
  logic clk = 0, rst = 1;
  logic ev_tx_empty = 0, ev_rx_full = 0, ev_rx_ready = 0, ev_rx_err = 0, ev_break = 0, ev_overrun = 0;
  logic lvl_tx_empty = 0, lvl_rx_full = 0, dma_tx_ack = 0, dma_rx_ack = 0;
  logic reg_addr = 0, reg_we = 0, reg_re = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic irq_tx, irq_rx, irq_err, irq_brk, dreq_tx, dreq_rx;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  sio_req_ctrl #(.DW(8)) uut (.*);

  always #10 clk = ~clk;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic logic [5:0] outs();
    return {dreq_rx, dreq_tx, irq_brk, irq_err, irq_rx, irq_tx};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk); endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_we = 1; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    reg_addr = a; reg_re = 1; #1 d = reg_rdata;
    @(negedge clk); reg_re = 0;
  endtask

  task automatic pulse(ref logic s);
    s = 1; @(negedge clk); s = 0;
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0;
    chk("R1 outputs", {2'b0, outs()}, 8'h00);
    rd(1, rv); chk("R1 status", rv, 8'h00);
    rd(0, rv); chk("R1 control", rv, 8'h00);
  endtask

  task automatic t_tx();
    wr(0, 8'h00);
    pulse(ev_tx_empty);
    rd(1, rv); chk("R11 flag set", rv, 8'h01);
    chk("R11 before output", {2'b0, outs()}, 8'h10);
    wr(0, 8'h01);
    chk("R11 ctrl lag", {2'b0, outs()}, 8'h10);
    settle();
    chk("R2 irq with enable", {2'b0, outs()}, 8'h11);
    pulse(dma_tx_ack); settle();
    chk("R9 tx ack clears", {2'b0, outs()}, 8'h00);
  endtask

  task automatic t_guard();
    lvl_tx_empty = 1;
    pulse(ev_tx_empty);
    pulse(dma_tx_ack); settle();
    chk("R10 tx guarded", {7'b0, dreq_tx}, 8'h01);
    rd(1, rv); wr(1, 8'h00); settle();
    chk("R10 sw guarded", {7'b0, dreq_tx}, 8'h01);
    lvl_tx_empty = 0;
    pulse(dma_tx_ack); settle();
    chk("R10 released", {7'b0, dreq_tx}, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_rx();
    wr(0, 8'h02);
    pulse(ev_rx_ready); settle();
    chk("R3 ready async", {2'b0, outs()}, 8'h22);
    pulse(dma_rx_ack); settle();
    chk("R9 rx ack clears", {2'b0, outs()}, 8'h00);
    wr(0, 8'h0A);
    pulse(ev_rx_ready); settle();
    chk("R4 ready sync quiet", {2'b0, outs()}, 8'h00);
    rd(1, rv); chk("R4 ready reads", rv, 8'h04);
    lvl_rx_full = 1;
    pulse(ev_rx_full); settle();
    chk("R4 full sync", {2'b0, outs()}, 8'h22);
    pulse(dma_rx_ack); settle();
    chk("R10 rx guarded", {2'b0, outs()}, 8'h22);
    lvl_rx_full = 0;
    pulse(dma_rx_ack); settle();
    rd(1, rv); chk("R9 rx ack both flags", rv, 8'h00);
    wr(0, 8'h02); settle();
    chk("R3 no req after ack", {2'b0, outs()}, 8'h00);
  endtask

  task automatic t_err();
    wr(0, 8'h04);
    pulse(ev_rx_err); settle();
    chk("R5 err only enable", {2'b0, outs()}, 8'h04);
    wr(0, 8'h00); settle();
    chk("R5 err masked", {2'b0, outs()}, 8'h00);
    wr(1, 8'h00); rd(1, rv);
    chk("R7 no read no clear", rv, 8'h08);
    wr(1, 8'hFF); rd(1, rv);
    chk("R7 write one ignored", rv, 8'h08);
    wr(1, 8'h00); rd(1, rv);
    chk("R7 clear after read", rv, 8'h00);
  endtask

  task automatic t_brk();
    pulse(ev_overrun); settle();
    chk("R6 overrun", {2'b0, outs()}, 8'h08);
    rd(1, rv); wr(1, 8'h00); settle();
    chk("R6 cleared", {2'b0, outs()}, 8'h00);
    pulse(ev_break); settle();
    chk("R6 break", {2'b0, outs()}, 8'h08);
    rd(1, rv); wr(1, 8'h00); settle();
  endtask

  task automatic t_race();
    pulse(ev_tx_empty);
    rd(1, rv);
    reg_addr = 1; reg_we = 1; reg_wdata = 8'h00; ev_tx_empty = 1;
    @(negedge clk); reg_we = 0; ev_tx_empty = 0;
    rd(1, rv); chk("R8 sw clear vs set", rv, 8'h01);
    dma_tx_ack = 1; ev_tx_empty = 1;
    @(negedge clk); dma_tx_ack = 0; ev_tx_empty = 0;
    settle();
    chk("R8 dma ack vs set", {7'b0, dreq_tx}, 8'h01);
    pulse(dma_tx_ack); settle();
    chk("R9 final clear", {2'b0, outs()}, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_tx();
    t_guard();
    t_rx();
    t_err();
    t_brk();
    t_race();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule